// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps the state of a bank of interrupt vectors (256 by default) for one processor. It holds three bit sets over the vector space: vectors waiting for service, vectors being serviced, and the trigger type (level or edge) that was last recorded for each vector. Interrupt sources post a vector together with a level or edge flag. A leading-one search finds the best pending vector and the best in-service vector, where a lower vector index ranks higher. The block raises a registered interrupt line toward the processor whenever the best pending vector outranks all work in service.

The processor takes an interrupt with an acknowledge strobe. In the same cycle the block returns the winning vector and moves it from the pending set to the in-service set. An end-of-interrupt strobe retires the best in-service vector. The block also derives a processor priority value from an external task-priority input and the in-service state. Each set can be read as 32-bit words through a small read port.

Top module: `vec_prio_tracker`

## Requirements
- R1: After reset, all three sets are empty, `cpu_irq` is 0 and `ack_valid` is 0.
- R2: When `set_valid` is high, vector `set_vec` becomes pending at the next edge. Its trigger bit becomes 1 if `set_level` is 1 (level) and 0 if it is 0 (edge).
- R3: The winner of a set is its lowest-numbered set bit. While `ack_req` is high and the request is accepted, `ack_vec` shows the pending winner in the same cycle. When nothing is pending, `ack_valid` stays 0.
- R4: An accepted acknowledge (`ack_req`=1, `sw_enable`=1, pending set non-empty) drives `ack_valid`=1 combinationally. At the next edge it clears the winner from the pending set and sets it in the in-service set.
- R5: While `sw_enable` is 0, an acknowledge is refused. `ack_valid` stays 0, and the pending and in-service sets are left unchanged by it.
- R6: `eoi` clears the lowest-numbered in-service bit at the next edge. When the in-service set is empty, `eoi` changes nothing.
- R7: `cpu_irq` is a register loaded every cycle. It is loaded with 1 exactly when, in the cycle before, the pending set was non-empty and either the in-service set was empty or the pending winner index was strictly lower than the in-service winner index.
- R8: `ppr` is computed from the task class `tpr[7:4]` and the in-service class (in-service winner >> 4, taken as 0 when nothing is in service). If the task class is greater than or equal to the in-service class, `ppr` equals `tpr`; otherwise `ppr` equals the in-service class shifted left by 4.
- R9: When several operations fall in one cycle, all of them read the state from before that cycle. They are applied in this order: the EOI clear first, then the acknowledge move, then the set request. A set of the vector being acknowledged therefore leaves it pending.
- R10: The read port returns word `rd_word` of the selected set, where vector v lies in word v>>5 at bit v&31. Selector `rd_sel` encodes 0 = pending, 1 = in-service, 2 = trigger, and 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_enable | input | 1 | Software enable; acknowledges are refused while low |
| tpr | input | 8 | Task priority value |
| set_valid | input | 1 | Post a vector request this cycle |
| set_vec | input | 8 | Vector being posted |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| ack_valid | output | 1 | Acknowledge accepted this cycle |
| ack_vec | output | 8 | Pending winner returned on acknowledge |
| eoi | input | 1 | End-of-interrupt strobe |
| cpu_irq | output | 1 | Registered interrupt request to the processor |
| ppr | output | 8 | Processor priority |
| rd_sel | input | 2 | Set selector for the read port |
| rd_word | input | 3 | Word index for the read port |
| rd_data | output | 32 | Selected 32-bit word |

## Verification
The assertions assume that every input is a known value at each rising edge once reset is released, and that strobes are single-cycle levels sampled on that edge. They allow any mix of set, acknowledge and EOI in the same cycle. The bench changes inputs only on falling edges. Its random stimulus draws vectors sometimes from a narrow range, so that set, acknowledge and EOI often hit the same vector, and it switches the enable low now and then. It also keeps the read selector inside its four codes, so the ordering rule and the refused-acknowledge path see real traffic.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_INSV = 2'd1,
    SEL_TRIG = 2'd2,
    SEL_ZERO = 2'd3
  } set_sel_e;

  localparam int CLASS_SHIFT = 4;
endpackage

// File: rtl/vpt_first_set.sv
module vpt_first_set #(
  parameter int W     = 256,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Lowest set index wins: scan downward so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) idx = IDX_W'(i);
    end
  end

  assign found = |bits;
endmodule

// File: rtl/vpt_ppr.sv
module vpt_ppr #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_any,
  input  logic [VEC_W-1:0] isr_top,
  output logic [VEC_W-1:0] ppr
);
  import vpt_pkg::*;

  localparam int CLS_W = VEC_W - CLASS_SHIFT;

  logic [CLS_W-1:0] task_cls;
  logic [CLS_W-1:0] svc_cls;

  always_comb begin
    task_cls = tpr[VEC_W-1:CLASS_SHIFT];
    svc_cls  = isr_any ? isr_top[VEC_W-1:CLASS_SHIFT] : '0;
    if (task_cls >= svc_cls) ppr = tpr;
    else                     ppr = {svc_cls, {CLASS_SHIFT{1'b0}}};
  end

  // R8: the resulting class never drops below either input class
  a_r8_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (ppr[VEC_W-1:CLASS_SHIFT] >= tpr[VEC_W-1:CLASS_SHIFT]) &&
    (!isr_any || ppr[VEC_W-1:CLASS_SHIFT] >= isr_top[VEC_W-1:CLASS_SHIFT]));
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int VEC_W   = $clog2(NUM_VEC),
  parameter int WSEL_W  = $clog2(NUM_VEC / WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_enable,
  input  logic [VEC_W-1:0]  tpr,
  input  logic              set_valid,
  input  logic [VEC_W-1:0]  set_vec,
  input  logic              set_level,
  input  logic              ack_req,
  output logic              ack_valid,
  output logic [VEC_W-1:0]  ack_vec,
  input  logic              eoi,
  output logic              cpu_irq,
  output logic [VEC_W-1:0]  ppr,
  input  logic [1:0]        rd_sel,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data
);
  import vpt_pkg::*;

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [NUM_VEC-1:0] pend_q, insv_q, trig_q;
  logic [NUM_VEC-1:0] pend_d, insv_d, trig_d;
  logic               irq_q, irq_d;
  logic               pend_any, insv_any;
  logic [VEC_W-1:0]   pend_top, insv_top;
  logic               ack_fire, eoi_fire;

  vpt_first_set #(.W(NUM_VEC), .IDX_W(VEC_W)) u_pend_find (
    .bits(pend_q), .found(pend_any), .idx(pend_top));
  vpt_first_set #(.W(NUM_VEC), .IDX_W(VEC_W)) u_insv_find (
    .bits(insv_q), .found(insv_any), .idx(insv_top));

  vpt_ppr #(.VEC_W(VEC_W)) u_ppr (
    .clk(clk), .rst_n(rst_sn), .tpr(tpr),
    .isr_any(insv_any), .isr_top(insv_top), .ppr(ppr));

  assign ack_fire  = ack_req && sw_enable && pend_any;
  assign eoi_fire  = eoi && insv_any;
  assign ack_valid = ack_fire;
  assign ack_vec   = pend_top;
  assign cpu_irq   = irq_q;

  // next state: EOI clear, then acknowledge move, then set request
  always_comb begin
    pend_d = pend_q;
    insv_d = insv_q;
    trig_d = trig_q;
    if (eoi_fire) insv_d[insv_top] = 1'b0;
    if (ack_fire) begin
      pend_d[pend_top] = 1'b0;
      insv_d[pend_top] = 1'b1;
    end
    if (set_valid) begin
      pend_d[set_vec] = 1'b1;
      trig_d[set_vec] = set_level;
    end
    irq_d = pend_any && (!insv_any || (pend_top < insv_top));
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_q <= '0;
      insv_q <= '0;
      trig_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      insv_q <= insv_d;
      trig_q <= trig_d;
      irq_q  <= irq_d;
    end
  end

  // read port
  logic [NUM_VEC-1:0] rd_set;
  always_comb begin
    case (set_sel_e'(rd_sel))
      SEL_PEND: rd_set = pend_q;
      SEL_INSV: rd_set = insv_q;
      SEL_TRIG: rd_set = trig_q;
      default:  rd_set = '0;
    endcase
    rd_data = rd_set[rd_word*WORD_W +: WORD_W];
  end

  // R2: a posted vector is pending with its trigger type next cycle
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_sn)
    set_valid |=> (pend_q[$past(set_vec)] && trig_q[$past(set_vec)] == $past(set_level)));
  // R3: a returned vector was really pending
  a_r3_ack_is_pending: assert property (@(posedge clk) disable iff (!rst_sn)
    ack_valid |-> pend_q[ack_vec]);
  // R4: an acknowledged vector is in service next cycle
  a_r4_ack_to_service: assert property (@(posedge clk) disable iff (!rst_sn)
    ack_valid |=> insv_q[$past(ack_vec)]);
  // R4: and it leaves the pending set unless re-posted
  a_r4_ack_clears_pend: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack_valid && !(set_valid && set_vec == ack_vec)) |=> !pend_q[$past(ack_vec)]);
  // R5: refused while software enable is low
  a_r5_ack_refused: assert property (@(posedge clk) disable iff (!rst_sn)
    !sw_enable |-> !ack_valid);
  // R6: EOI retires the top in-service vector
  a_r6_eoi_retires: assert property (@(posedge clk) disable iff (!rst_sn)
    (eoi && insv_any && !(ack_valid && ack_vec == insv_top)) |=> !insv_q[$past(insv_top)]);
  // R7: interrupt line only follows a non-empty pending set
  a_r7_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_sn)
    cpu_irq |-> $past(pend_any));
endmodule

// File: tb/vec_prio_tracker_tb.sv
`timescale 1ns/1ps
module vec_prio_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_enable, set_valid, set_level, ack_req, eoi;
  logic [7:0]  tpr, set_vec;
  logic [1:0]  rd_sel;
  logic [2:0]  rd_word;
  logic        ack_valid, cpu_irq;
  logic [7:0]  ack_vec, ppr;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  vec_prio_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .tpr(tpr),
    .set_valid(set_valid), .set_vec(set_vec), .set_level(set_level),
    .ack_req(ack_req), .ack_valid(ack_valid), .ack_vec(ack_vec), .eoi(eoi),
    .cpu_irq(cpu_irq), .ppr(ppr), .rd_sel(rd_sel), .rd_word(rd_word),
    .rd_data(rd_data));

  logic [255:0] m_pend, m_insv, m_trig;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int first_bit(logic [255:0] b);
    for (int i = 0; i < 256; i++) if (b[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_ppr(logic [7:0] t);
    int s = first_bit(m_insv);
    int sc = (s < 0) ? 0 : (s >> 4);
    return (int'(t >> 4) >= sc) ? t : 8'(sc << 4);
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] sel, logic [2:0] w);
    case (sel)
      2'd0: return m_pend[w*32 +: 32];
      2'd1: return m_insv[w*32 +: 32];
      2'd2: return m_trig[w*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit sv, logic [7:0] v, bit lvl, bit ak, bit eo, bit en,
                      logic [7:0] t, logic [1:0] rs, logic [2:0] rw);
    int pt, st;
    bit fire, irq_exp;
    @(negedge clk);
    set_valid = sv; set_vec = v; set_level = lvl; ack_req = ak; eoi = eo;
    sw_enable = en; tpr = t; rd_sel = rs; rd_word = rw;
    #1;
    pt = first_bit(m_pend);
    st = first_bit(m_insv);
    fire = ak && en && (pt >= 0);
    chk(ack_valid == fire, fire ? "R4 ack_valid" : "R5/R3 ack_valid", 32'(ack_valid), 32'(fire));
    if (fire) chk(ack_vec == 8'(pt), "R3 ack_vec winner", 32'(ack_vec), 32'(pt));
    chk(ppr == exp_ppr(t), "R8 ppr", 32'(ppr), 32'(exp_ppr(t)));
    chk(rd_data == exp_rd(rs, rw), "R10 rd_data", rd_data, exp_rd(rs, rw));
    irq_exp = (pt >= 0) && (st < 0 || pt < st);
    // R9 order: eoi clear, ack move, set request
    if (eo && st >= 0) m_insv[st] = 1'b0;
    if (fire) begin m_pend[pt] = 1'b0; m_insv[pt] = 1'b1; end
    if (sv) begin m_pend[v] = 1'b1; m_trig[v] = lvl; end
    @(posedge clk);
    #1;
    chk(cpu_irq == irq_exp, "R7 cpu_irq", 32'(cpu_irq), 32'(irq_exp));
  endtask

  task automatic idle(logic [1:0] rs, logic [2:0] rw);
    step(0, 8'd0, 0, 0, 0, 1, 8'h00, rs, rw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_pend = '0; m_insv = '0; m_trig = '0;
    rst_n = 0; sw_enable = 1; tpr = 0; set_valid = 0; set_vec = 0; set_level = 0;
    ack_req = 0; eoi = 0; rd_sel = 0; rd_word = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(cpu_irq == 0, "R1 cpu_irq after reset", 32'(cpu_irq), 0);
    chk(ack_valid == 0, "R1 ack_valid after reset", 32'(ack_valid), 0);
    for (int s = 0; s < 3; s++)
      for (int w = 0; w < 8; w++) idle(2'(s), 3'(w));
    // R3: acknowledge with nothing pending
    step(0, 0, 0, 1, 0, 1, 0, 0, 0);
    // R6: EOI on empty in-service set
    step(0, 0, 0, 0, 1, 1, 0, 1, 0);
    // R2: level and edge posts, trigger word read
    step(1, 8'd40, 1, 0, 0, 1, 0, 2, 1);
    step(1, 8'd10, 0, 0, 0, 1, 0, 2, 1);
    idle(2, 1); idle(0, 0);
    // R4: acknowledge returns 10
    step(0, 0, 0, 1, 0, 1, 8'h20, 1, 0);
    idle(1, 0);
    // R7: lower vector raises irq above the in-service one
    step(1, 8'd5, 0, 0, 0, 1, 0, 0, 0);
    idle(0, 0); idle(0, 0);
    // R5: refused while disabled
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    idle(0, 0); idle(1, 0);
    // R9: re-post of the vector being acknowledged stays pending
    step(1, 8'd5, 1, 1, 0, 1, 0, 0, 0);
    idle(0, 0);
    // R9: EOI and acknowledge of the same vector in one cycle
    step(0, 0, 0, 1, 1, 1, 8'hF0, 1, 0);
    idle(1, 0);
    // R6: retire everything
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, 1, 8'h35, 1, 1);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] v;
      v = ($urandom % 2) ? 8'($urandom % 24) : 8'($urandom);
      step(($urandom % 2) == 0, v, $urandom % 2, ($urandom % 4) == 0,
           ($urandom % 5) == 0, ($urandom % 8) != 0, 8'($urandom),
           2'($urandom), 3'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule